// File: doc/BRIEF.md
# Low-Power Wake-Up Scheduler with Receiver Duty Cycling

This block schedules periodic wake-ups for a low-power radio controller. A free-running prescaler divides the system clock into a slow tick, nominally one millisecond. Arming the timer starts a countdown of `M·2^R` ticks, where `M` is an 8-bit mantissa and `R` a 5-bit exponent. A fixed offset of `OFF_TICKS` ticks is added to that count. When the countdown expires, a sticky wake-up flag is raised. A status read clears the flag.

Each arming gives exactly one event. To run continuously, the controller must drop the enable and raise it again at the end of every cycle. The operand values are captured at the arming edge. An exponent larger than 29 is treated as 29.

With duty cycling enabled, the receiver-enable output is driven high from the arming edge for `(2·D+1)·2^R` ticks. This is a fraction `(2D+1)/M` of the period. While a signal-quality input reports a good signal at the end of that window, the window is stretched. Once the indication drops, the receiver stays off until the next arming.

Top module: `wakeup_sched`

## Requirements
- R1: After reset, `wake_flag` and `rx_on` are both low.
- R2: A 0-to-1 transition of `tmr_en` (sampled on the clock) with `mant` nonzero arms the timer. `wake_flag` goes high exactly `((mant << expo) + OFF_TICKS) · TICK_DIV` clock cycles after the arming edge.
- R3: An armed timer produces one event only. While `tmr_en` stays high after expiry, no further event occurs, even after the flag is cleared.
- R4: Dropping `tmr_en` before expiry cancels the countdown, and no event is raised.
- R5: A one-cycle `stat_rd` pulse clears `wake_flag`. If an expiry coincides with the read, the flag is left set.
- R6: Arming with `mant` equal to 0 never starts the countdown. No event is raised and `rx_on` stays low.
- R7: With `duty_en` high, `rx_on` is high from the cycle after the arming edge for `((2·duty+1) << expo) · TICK_DIV` cycles, and then goes low if `sig_good` is low.
- R8: When `sig_good` is high at the end of the window, `rx_on` stays high. It falls on the clock edge at which `sig_good` is first sampled low, and does not return before the next arming.
- R9: `rx_on` is low whenever `duty_en` is low or the timer is not running, including after expiry. A window longer than the period ends at expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mant | input | MANT_W | Period mantissa M, captured on arming |
| expo | input | EXP_W | Period exponent R, captured on arming; capped at 29 |
| tmr_en | input | 1 | Timer enable; a rising transition arms one countdown |
| duty | input | DUTY_W | Duty parameter D, captured on arming |
| duty_en | input | 1 | Enables receiver duty cycling |
| sig_good | input | 1 | Signal-quality indication, high while reception is good |
| stat_rd | input | 1 | Status read strobe; clears the wake-up flag |
| wake_flag | output | 1 | Sticky wake-up event flag |
| rx_on | output | 1 | Receiver enable |

## Verification
The assertions assume that `duty_en` is held steady for the whole of a run. If it were toggled mid-period, `rx_on` could rise without an arming edge. They also assume that `tmr_en` is driven from a clocked source, so that an arming is always a clean single-cycle transition.

The stimulus honours both assumptions:
- Every scenario sets the operands and `duty_en` at a falling clock edge, together with the `tmr_en` rise.
- `duty_en` is changed only while the timer is idle.
- `sig_good` changes only one time unit after a rising edge.

// File: rtl/wakeup_sched.sv
module wakeup_sched #(
  parameter int TICK_DIV  = 1000,
  parameter int OFF_TICKS = 1,
  parameter int MANT_W    = 8,
  parameter int EXP_W     = 5,
  parameter int DUTY_W    = 7,
  parameter int R_MAX     = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  expo,
  input  logic              tmr_en,
  input  logic [DUTY_W-1:0] duty,
  input  logic              duty_en,
  input  logic              sig_good,
  input  logic              stat_rd,
  output logic              wake_flag,
  output logic              rx_on
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CNT_W = MANT_W + R_MAX + 2;
  localparam logic [EXP_W-1:0] R_CAP = EXP_W'(R_MAX);

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] el, per_len, win_len;
  logic             running, en_q, hold;

  wire [EXP_W-1:0] r_eff  = (expo > R_CAP) ? R_CAP : expo;
  wire             arm    = tmr_en & ~en_q & (mant != '0);
  wire             tick   = (pre == PRE_W'(TICK_DIV - 1));
  wire             expire = running & tick & (el == per_len - 1'b1);

  assign rx_on = running & duty_en & ((el < win_len) | hold);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre       <= '0;
      el        <= '0;
      per_len   <= '0;
      win_len   <= '0;
      running   <= 1'b0;
      en_q      <= 1'b0;
      hold      <= 1'b0;
      wake_flag <= 1'b0;
    end else begin
      en_q <= tmr_en;
      hold <= rx_on & sig_good;
      if (arm) begin
        running <= 1'b1;
        pre     <= '0;
        el      <= '0;
        per_len <= (CNT_W'(mant) << r_eff) + CNT_W'(OFF_TICKS);
        win_len <= CNT_W'({duty, 1'b1}) << r_eff;
      end else if (!tmr_en || expire) begin
        running <= 1'b0;
      end else if (running) begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) el <= el + 1'b1;
      end
      if (expire) wake_flag <= 1'b1;
      else if (stat_rd) wake_flag <= 1'b0;
    end
  end
endmodule

module wakeup_sched_chk #(
  parameter int MANT_W = 8,
  parameter int CNT_W  = 39
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tmr_en,
  input logic              stat_rd,
  input logic [MANT_W-1:0] mant,
  input logic              wake_flag,
  input logic              rx_on,
  input logic              running,
  input logic              en_q,
  input logic              expire,
  input logic [CNT_W-1:0]  el,
  input logic [CNT_W-1:0]  per_len
);
  assert_flag_from_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past(running));

  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (el < per_len));

  assert_start_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> ($past(tmr_en) && !$past(en_q)));

  assert_stop_on_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tmr_en) |=> !running);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !expire) |=> !wake_flag);

  assert_zero_mant_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> ($past(mant) != '0));

  assert_rx_only_at_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_on) |-> $rose(running));
endmodule

bind wakeup_sched wakeup_sched_chk #(.MANT_W(MANT_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .stat_rd(stat_rd), .mant(mant),
  .wake_flag(wake_flag), .rx_on(rx_on), .running(running), .en_q(en_q),
  .expire(expire), .el(el), .per_len(per_len)
);

// File: tb/test_wakeup_sched.sv
module test_wakeup_sched;
  localparam int CLK_PERIOD = 10;
  localparam int TD  = 4;
  localparam int OFF = 1;

  logic clk = 0, rst_n = 0;
  logic [7:0] mant = 0;
  logic [4:0] expo = 0;
  logic [6:0] duty = 0;
  logic tmr_en = 0, duty_en = 0, sig_good = 0, stat_rd = 0;
  logic wake_flag, rx_on;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wakeup_sched #(.TICK_DIV(TD), .OFF_TICKS(OFF)) i_wakeup_sched (
    .clk(clk), .rst_n(rst_n), .mant(mant), .expo(expo), .tmr_en(tmr_en),
    .duty(duty), .duty_en(duty_en), .sig_good(sig_good), .stat_rd(stat_rd),
    .wake_flag(wake_flag), .rx_on(rx_on));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic int cyc_per(input int m, input int r);
    return ((m << r) + OFF) * TD;
  endfunction

  task automatic disarm();
    @(negedge clk) tmr_en = 0;
    @(posedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk) stat_rd = 1;
    @(negedge clk) stat_rd = 0;
  endtask

  task automatic arm(input int m, input int r, input int d, input logic den);
    disarm();
    clear_flag();
    @(negedge clk);
    mant = 8'(m); expo = 5'(r); duty = 7'(d); duty_en = den; tmr_en = 1;
    @(posedge clk);
  endtask

  task automatic t_period(input int m, input int r);
    arm(m, r, 0, 0);
    repeat (cyc_per(m, r) - 1) @(posedge clk);
    #1 chk("R2 before expiry", wake_flag, 0);
    @(posedge clk);
    #1 chk("R2 at expiry", wake_flag, 1);
  endtask

  task automatic t_one_shot();
    t_period(2, 1);
    clear_flag();
    #1 chk("R5 read clears", wake_flag, 0);
    repeat (3 * cyc_per(2, 1)) @(posedge clk);
    #1 chk("R3 no second event", wake_flag, 0);
  endtask

  task automatic t_cancel();
    arm(4, 2, 0, 0);
    repeat (10) @(posedge clk);
    disarm();
    repeat (cyc_per(4, 2) + 20) @(posedge clk);
    #1 chk("R4 cancelled", wake_flag, 0);
  endtask

  task automatic t_zero();
    arm(0, 2, 3, 1);
    #1 chk("R6 rx idle", rx_on, 0);
    repeat (100) @(posedge clk);
    #1 chk("R6 no event", wake_flag, 0);
  endtask

  task automatic t_window();
    sig_good = 0;
    arm(8, 1, 1, 1);
    #1 chk("R7 on at start", rx_on, 1);
    repeat (23) @(posedge clk);
    #1 chk("R7 last window cycle", rx_on, 1);
    @(posedge clk);
    #1 chk("R7 window ended", rx_on, 0);
  endtask

  task automatic t_stretch();
    sig_good = 1;
    arm(8, 1, 1, 1);
    repeat (30) @(posedge clk);
    #1 chk("R8 stretched", rx_on, 1);
    sig_good = 0;
    @(posedge clk);
    #1 chk("R8 ends on drop", rx_on, 0);
    sig_good = 1;
    repeat (5) @(posedge clk);
    #1 chk("R8 stays off", rx_on, 0);
    repeat (32) @(posedge clk);
    #1 chk("R2 duty run expiry", wake_flag, 1);
    chk("R9 off after expiry", rx_on, 0);
    sig_good = 0;
  endtask

  task automatic t_no_duty();
    arm(8, 1, 1, 0);
    #1 chk("R9 duty off start", rx_on, 0);
    repeat (10) @(posedge clk);
    #1 chk("R9 duty off mid", rx_on, 0);
  endtask

  task automatic t_long_window();
    sig_good = 0;
    arm(2, 0, 127, 1);
    repeat (cyc_per(2, 0) - 1) @(posedge clk);
    #1 chk("R9 long window held", rx_on, 1);
    @(posedge clk);
    #1 chk("R9 long window ends at expiry", rx_on, 0);
    chk("R2 short period", wake_flag, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1 flag reset", wake_flag, 0);
    chk("R1 rx reset", rx_on, 0);
    @(negedge clk) rst_n = 1;
    t_period(3, 1);
    t_period(5, 0);
    t_period(1, 3);
    t_one_shot();
    t_cancel();
    t_zero();
    t_window();
    t_stretch();
    t_no_duty();
    t_long_window();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule